// File: doc/BRIEF.md
# Clause-wise TCAM error-scrub key sequencer

This controller verifies that every stored entry of a ternary CAM still holds consistent symbols, using nothing but the array's own parallel search. Each entry is split into `NUM_CLAUSES` clauses. A clause is `K` data symbols followed by one check symbol, so it is `K+1` columns wide. Ternary symbols are treated as GF(3) values: `1` is +1, `0` is -1, and don't-care is 0. A clause is consistent when these values sum to zero modulo 3. The sequencer visits the clauses in ascending order. For each clause it drives a fixed family of binary search keys into that clause's columns and masks every other column. The array keeps a one-bit parity register per match line and XORs each search result into it. A clause that matched an odd number of keys is corrupt. After the keys of a clause are used up, the sequencer folds the parity vector into a sticky per-entry error vector and clears the parity registers.

The number of searches depends only on the entry width (`NUM_CLAUSES`, `K`) and not on how many entries are stored. The key family for a clause of `w = K+1` columns is every binary word whose GF(3) sum is nonzero. There are `2(2^w - (-1)^w)/3` such words.

Top module: `clause_scrub_seq`

## Requirements
- R1: While `rst_ni` is low and after reset, `search_o`, `acc_o`, `clr_o` and `done_o` are 0, `key_care_o` is all zeros and `err_o` is all zeros.
- R2: For each clause, the block issues one `search_o` strobe for every binary word p of `CW=K+1` bits whose value `(#ones·1 + #zeros·2) mod 3` is nonzero, in ascending numeric order of p. Bit j of p drives column `c*CW+j` of clause c. Per clause this gives `2(2^CW-(-1)^CW)/3` strobes (6 for K=2).
- R3: During a strobe, `key_care_o` is 1 exactly on the CW columns of the current clause. Every other column has care 0 and value 0, which is don't-care. With no strobe, all care bits are 0.
- R4: Clauses run in ascending order. Each clause takes `2^CW+2` cycles. `done_o` is a one-cycle pulse that is visible `NUM_CLAUSES*(2^CW+2)+1` cycles after the edge that sampled `start_i`.
- R5: `acc_o` is high in exactly the cycle after each strobe.
- R6: Once per clause, two cycles after the clause's last key pattern, `clr_o` is high for one cycle. In that same cycle `parity_i` is ORed into `err_o`.
- R7: Bit e of `err_o` is 1 after a scan iff entry e has a clause that matched an odd number of keys. This holds exactly when the clause's GF(3) sum is nonzero. Two errors that leave the sum unchanged are not flagged.
- R8: `err_o` is cleared at the edge that accepts `start_i` and holds its value from `done_o` until the next start.
- R9: `start_i` is ignored while a scan is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scan when idle |
| parity_i | input | NUM_ENTRIES | Per-line parity registers of the array |
| search_o | output | 1 | Search strobe |
| key_val_o | output | COLS | Search key value per column |
| key_care_o | output | COLS | 1 = column compared, 0 = don't-care |
| acc_o | output | 1 | Accumulate this cycle's match result into parity |
| clr_o | output | 1 | Clear parity registers at end of cycle |
| done_o | output | 1 | Scan complete pulse |
| err_o | output | NUM_ENTRIES | Sticky per-entry error flags |

## Verification
The bench models the array. It captures match results at the edge that closes a search cycle, applies them when `acc_o` is high one cycle later, and clears them at the edge that closes the `clr_o` cycle. As a result, `parity_i` is settled when the design samples it, two cycles after the last key. The `done_o` pulse is expected in the cycle counted by the R4 formula. All outputs are sampled at the falling edge, and the cycle count starts at the first falling edge after the start edge. The error vector is compared with a GF(3) sum of the bench's stored image, and its clearing is checked one cycle after start.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_DRAIN,
    ST_SAMPLE,
    ST_FIN
  } scrub_state_e;
endpackage

// File: rtl/scrub_key_gen.sv
module scrub_key_gen #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          step_i,
  output logic [CW-1:0] pat_o,
  output logic          valid_o,
  output logic          last_o
);
  logic [CW-1:0] pat_q;

  // word belongs to the key set when its GF(3) sum (1->+1, 0->-1) is nonzero
  function automatic logic in_key_set(input logic [CW-1:0] p);
    int unsigned ones;
    ones = 0;
    for (int i = 0; i < CW; i++) ones += p[i];
    return ((ones + CW) % 3) != 0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pat_q <= '0;
    else if (restart_i) pat_q <= '0;
    else if (step_i)    pat_q <= pat_q + 1'b1;
  end

  assign pat_o   = pat_q;
  assign valid_o = in_key_set(pat_q);
  assign last_o  = &pat_q;
endmodule

// File: rtl/scrub_key_place.sv
module scrub_key_place #(
  parameter int unsigned CW          = 3,
  parameter int unsigned NUM_CLAUSES = 3,
  parameter int unsigned CLW         = 2,
  localparam int unsigned COLS       = CW * NUM_CLAUSES
) (
  input  logic            en_i,
  input  logic [CLW-1:0]  sel_i,
  input  logic [CW-1:0]   pat_i,
  output logic [COLS-1:0] val_o,
  output logic [COLS-1:0] care_o
);
  for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_clause
    logic hit;
    assign hit = en_i && (sel_i == CLW'(c));
    assign val_o[c*CW +: CW]  = hit ? pat_i : '0;
    assign care_o[c*CW +: CW] = {CW{hit}};
  end
endmodule

// File: rtl/scrub_err_acc.sv
module scrub_err_acc #(
  parameter int unsigned NUM_ENTRIES = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   load_i,
  input  logic [NUM_ENTRIES-1:0] parity_i,
  output logic [NUM_ENTRIES-1:0] err_o
);
  logic [NUM_ENTRIES-1:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= '0;
    else if (clear_i) err_q <= '0;
    else if (load_i)  err_q <= err_q | parity_i;
  end

  assign err_o = err_q;
endmodule

// File: rtl/clause_scrub_seq.sv
module clause_scrub_seq
  import scrub_pkg::*;
#(
  parameter int unsigned K           = 2,
  parameter int unsigned NUM_CLAUSES = 3,
  parameter int unsigned NUM_ENTRIES = 8,
  localparam int unsigned CW         = K + 1,
  localparam int unsigned COLS       = CW * NUM_CLAUSES,
  localparam int unsigned CLW        = (NUM_CLAUSES > 1) ? $clog2(NUM_CLAUSES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [NUM_ENTRIES-1:0] parity_i,
  output logic                   search_o,
  output logic [COLS-1:0]        key_val_o,
  output logic [COLS-1:0]        key_care_o,
  output logic                   acc_o,
  output logic                   clr_o,
  output logic                   done_o,
  output logic [NUM_ENTRIES-1:0] err_o
);
  scrub_state_e   state_q, state_d;
  logic [CLW-1:0] clause_q;
  logic           acc_q;
  logic [CW-1:0]  pat;
  logic           pat_valid, pat_last;
  logic           in_search, accept;

  assign in_search = (state_q == ST_SEARCH);
  assign accept    = (state_q == ST_IDLE) && start_i;

  scrub_key_gen #(.CW(CW)) i_key_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (accept || state_q == ST_SAMPLE),
    .step_i    (in_search),
    .pat_o     (pat),
    .valid_o   (pat_valid),
    .last_o    (pat_last)
  );

  assign search_o = in_search && pat_valid;

  scrub_key_place #(.CW(CW), .NUM_CLAUSES(NUM_CLAUSES), .CLW(CLW)) i_key_place (
    .en_i   (search_o),
    .sel_i  (clause_q),
    .pat_i  (pat),
    .val_o  (key_val_o),
    .care_o (key_care_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_SEARCH;
      ST_SEARCH: if (pat_last) state_d = ST_DRAIN;
      ST_DRAIN:  state_d = ST_SAMPLE;
      ST_SAMPLE: state_d = (clause_q == CLW'(NUM_CLAUSES - 1)) ? ST_FIN : ST_SEARCH;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      clause_q <= '0;
      acc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      acc_q   <= search_o;   // match lines settle one cycle after the search
      if (accept)                  clause_q <= '0;
      else if (state_q == ST_SAMPLE) clause_q <= clause_q + 1'b1;
    end
  end

  assign acc_o  = acc_q;
  assign clr_o  = (state_q == ST_SAMPLE);
  assign done_o = (state_q == ST_FIN);

  scrub_err_acc #(.NUM_ENTRIES(NUM_ENTRIES)) i_err_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .load_i   (clr_o),
    .parity_i (parity_i),
    .err_o    (err_o)
  );
endmodule

module clause_scrub_seq_chk #(
  parameter int unsigned CW          = 3,
  parameter int unsigned COLS        = 9,
  parameter int unsigned NUM_ENTRIES = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic                   search_o,
  input logic [COLS-1:0]        key_val_o,
  input logic [COLS-1:0]        key_care_o,
  input logic                   acc_o,
  input logic                   clr_o,
  input logic                   done_o,
  input logic [NUM_ENTRIES-1:0] err_o
);
  // R3
  care_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_o |-> ($countones(key_care_o) == CW));
  // R3
  idle_care_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !search_o |-> (key_care_o == '0 && key_val_o == '0));
  // R3
  val_in_care_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_val_o & ~key_care_o) == '0);
  // R5
  acc_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_o |=> acc_o);
  // R5
  acc_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |-> $past(search_o));
  // R6
  clr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o && !acc_o);
  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_o && !start_i) |=> $stable(err_o));
  // R2
  no_search_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !search_o && !clr_o);
endmodule

bind clause_scrub_seq clause_scrub_seq_chk #(
  .CW(CW), .COLS(COLS), .NUM_ENTRIES(NUM_ENTRIES)
) i_scrub_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .search_o   (search_o),
  .key_val_o  (key_val_o),
  .key_care_o (key_care_o),
  .acc_o      (acc_o),
  .clr_o      (clr_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/test_clause_scrub_seq.sv
module test_clause_scrub_seq;
  localparam int K    = 2;
  localparam int NC   = 3;
  localparam int NE   = 8;
  localparam int CW   = K + 1;
  localparam int COLS = CW * NC;
  localparam int SCAN_CYC = NC * ((1 << CW) + 2) + 1;
  localparam int KEYS_PER = (2 * ((1 << CW) - (((CW % 2) == 1) ? -1 : 1))) / 3;

  // row: {entry mask[7:0], clause[1:0], kind[1:0]}
  // kind 0 none, 1 bump check symbol, 2 swap data 0/1, 3 bump data 0
  localparam int NROWS = 8;
  localparam logic [11:0] ROWS [NROWS] = '{
    {8'h00, 2'd0, 2'd0},
    {8'h01, 2'd0, 2'd1},
    {8'h80, 2'd2, 2'd1},
    {8'hA5, 2'd1, 2'd3},
    {8'hFF, 2'd2, 2'd2},
    {8'h3C, 2'd1, 2'd1},
    {8'hFF, 2'd0, 2'd3},
    {8'h5A, 2'd2, 2'd1}
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [NE-1:0]   parity_i;
  logic            search_o, acc_o, clr_o, done_o;
  logic [COLS-1:0] key_val_o, key_care_o;
  logic [NE-1:0]   err_o;

  clause_scrub_seq #(.K(K), .NUM_CLAUSES(NC), .NUM_ENTRIES(NE)) i_clause_scrub_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .parity_i(parity_i),
    .search_o(search_o), .key_val_o(key_val_o), .key_care_o(key_care_o),
    .acc_o(acc_o), .clr_o(clr_o), .done_o(done_o), .err_o(err_o)
  );

  always #2 clk_i = ~clk_i;

  int total = 0, bad = 0;
  int cyc_cnt = 0;
  bit wd_hit = 0;

  // symbols: 0 = '0', 1 = '1', 2 = don't-care
  int sym [NE][COLS];

  // array model
  logic [NE-1:0]   par_q = '0, m_q = '0;
  logic            s_search = 0, s_acc = 0, s_clr = 0;
  logic [NE-1:0]   s_match = '0;
  assign parity_i = par_q;

  // monitor state
  int srch_cnt, clr_cnt, key_bad, acc_bad, mon_clause, exp_next;
  logic prev_search = 0;

  function automatic int gf(int s);
    return (s == 1) ? 1 : ((s == 0) ? 2 : 0);
  endfunction

  function automatic logic [NE-1:0] match_vec(logic [COLS-1:0] v, logic [COLS-1:0] c);
    logic [NE-1:0] r;
    for (int e = 0; e < NE; e++) begin
      r[e] = 1'b1;
      for (int j = 0; j < COLS; j++)
        if (c[j] && sym[e][j] != 2 && sym[e][j] != int'(v[j])) r[e] = 1'b0;
    end
    return r;
  endfunction

  function automatic int next_key(int from);
    for (int p = from; p < (1 << CW); p++) begin
      int s;
      s = 0;
      for (int b = 0; b < CW; b++) s += ((p >> b) & 1) ? 1 : 2;
      if (s % 3 != 0) return p;
    end
    return -1;
  endfunction

  function automatic logic [NE-1:0] expected_err();
    logic [NE-1:0] r;
    r = '0;
    for (int e = 0; e < NE; e++)
      for (int c = 0; c < NC; c++) begin
        int s;
        s = 0;
        for (int j = 0; j < CW; j++) s += gf(sym[e][c*CW+j]);
        if (s % 3 != 0) r[e] = 1'b1;
      end
    return r;
  endfunction

  always @(negedge clk_i) begin
    s_search = search_o;
    s_acc    = acc_o;
    s_clr    = clr_o;
    s_match  = match_vec(key_val_o, key_care_o);
    if (acc_o !== prev_search) acc_bad++;
    prev_search = search_o;
    if (search_o) begin
      int ek;
      logic [COLS-1:0] ecare, eval;
      srch_cnt++;
      ek = next_key(exp_next);
      ecare = '0; eval = '0;
      if (ek >= 0 && mon_clause < NC) begin
        ecare[mon_clause*CW +: CW] = '1;
        eval[mon_clause*CW +: CW]  = CW'(ek);
      end
      if (ek < 0 || key_care_o !== ecare || key_val_o !== eval) key_bad++;
      exp_next = ek + 1;
    end else if (key_care_o !== '0) key_bad++;
    if (clr_o) begin
      clr_cnt++;
      mon_clause++;
      exp_next = 0;
    end
  end

  always @(posedge clk_i) begin
    if (s_clr)      par_q <= '0;
    else if (s_acc) par_q <= par_q ^ m_q;
    m_q <= s_search ? s_match : '0;
    cyc_cnt <= cyc_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [11:0] row);
    logic [7:0] mask;
    int cl, kind;
    mask = row[11:4]; cl = int'(row[3:2]); kind = int'(row[1:0]);
    for (int e = 0; e < NE; e++)
      for (int c = 0; c < NC; c++) begin
        int s;
        s = 0;
        for (int j = 0; j < K; j++) begin
          sym[e][c*CW+j] = (e + c + j) % 3;
          s += gf(sym[e][c*CW+j]);
        end
        case ((3 - s % 3) % 3)
          1: sym[e][c*CW+K] = 1;
          2: sym[e][c*CW+K] = 0;
          default: sym[e][c*CW+K] = 2;
        endcase
        if (mask[e] && c == cl) begin
          if (kind == 1) sym[e][c*CW+K] = (sym[e][c*CW+K] + 1) % 3;
          if (kind == 2) begin
            int t;
            t = sym[e][c*CW];
            sym[e][c*CW] = sym[e][c*CW+1];
            sym[e][c*CW+1] = t;
          end
          if (kind == 3) sym[e][c*CW] = (sym[e][c*CW] + 1) % 3;
        end
      end
  endtask

  // returns cycles until done and err_o one cycle after start
  task automatic run_scan(input bit busy_pulse, output int cyc, output logic [NE-1:0] err_at1);
    srch_cnt = 0; clr_cnt = 0; key_bad = 0; acc_bad = 0; mon_clause = 0; exp_next = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 1;
    err_at1 = err_o;
    while (!done_o && cyc < 400 && !wd_hit) begin
      start_i = busy_pulse && (cyc == 5 || cyc == 20);
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
  endtask

  initial begin
    int cyc;
    logic [NE-1:0] e1, exp_e;
    // R1 reset state
    #1;
    check(search_o == 0 && acc_o == 0 && clr_o == 0 && done_o == 0, "R1", 0, 0);
    check(err_o == '0 && key_care_o == '0, "R1", int'(err_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(search_o == 0 && done_o == 0 && err_o == '0, "R1", int'(err_o), 0);

    for (int r = 0; r < NROWS; r++) begin
      build(ROWS[r]);
      exp_e = expected_err();
      run_scan(1'b0, cyc, e1);
      check(cyc == SCAN_CYC && done_o, "R4", cyc, SCAN_CYC);
      check(err_o == exp_e, "R7", int'(err_o), int'(exp_e));
      check(srch_cnt == NC * KEYS_PER, "R2", srch_cnt, NC * KEYS_PER);
      check(key_bad == 0, "R3", key_bad, 0);
      check(acc_bad == 0, "R5", acc_bad, 0);
      check(clr_cnt == NC, "R6", clr_cnt, NC);
      @(negedge clk_i);
      check(!done_o, "R4", int'(done_o), 0);
    end

    // R7: swap in every entry of clause 2 keeps sums, so nothing flagged
    build(ROWS[4]);
    check(expected_err() == '0, "R7", int'(expected_err()), 0);

    // R8: hold after done, then clear on start
    build(ROWS[6]);
    exp_e = expected_err();
    run_scan(1'b0, cyc, e1);
    repeat (6) @(negedge clk_i);
    check(err_o == exp_e, "R8", int'(err_o), int'(exp_e));
    build(ROWS[0]);
    run_scan(1'b0, cyc, e1);
    check(e1 == '0, "R8", int'(e1), 0);
    check(err_o == '0, "R7", int'(err_o), 0);

    // R9: start pulses mid-scan are ignored
    build(ROWS[5]);
    exp_e = expected_err();
    run_scan(1'b1, cyc, e1);
    check(cyc == SCAN_CYC, "R9", cyc, SCAN_CYC);
    check(err_o == exp_e, "R9", int'(err_o), int'(exp_e));
    check(srch_cnt == NC * KEYS_PER && clr_cnt == NC, "R9", srch_cnt, NC * KEYS_PER);
    repeat (3) @(negedge clk_i);
    check(!search_o && !done_o, "R9", int'(search_o), 0);

    // R1: asynchronous reset mid-scan
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(!search_o && !acc_o && !clr_o && err_o == '0, "R1", int'(search_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    if (wd_hit) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc_cnt, 100000);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc_cnt > 100000);
    wd_hit = 1;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc_cnt, 100000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule